// File: doc/BRIEF.md
# Serial DAC Word Receiver with Selectable Echo Edge

This block is the front end of a 12-bit serial DAC. It receives a three-wire serial stream (active-low select, serial clock, data in), builds a 16-bit word, and hands that word to a downstream command decoder with a one-cycle strobe when the select line is released. It also drives a serial echo output. Several devices can be daisy-chained through this output, and it can be used to read back data that was shifted in.

The serial clock, select and data inputs arrive without a timing relation to the system clock. Each passes through a two-stage synchronizer, and every edge is detected in the system clock domain. The system clock must run at least four times faster than the serial clock. A mode input chooses which serial clock edge updates the echo output. With falling-edge launch the output lags the input by 16 serial clocks. With rising-edge launch it lags by 15.5 serial clocks. A shutdown input freezes the echo output at its last level. The word receiver keeps running while the echo is frozen.

Top module: `sdsr_top`

## Requirements
- R1: After reset, `dout_o` is 0, `word_valid_o` is 0 and `word_o` is 0.
- R2: While `cs_n_i` is low, each rising `sclk_i` edge captures `din_i`. Bits arrive MSB first. In the delivered word, bits [15:13] are the control field, bits [12:1] are the 12-bit data field (D11 down to D0), and bit [0] is the trailing sub-bit.
- R3: A word is delivered only after `cs_n_i` rises following exactly 16 captured bits. Delivery is a single-cycle `word_valid_o` pulse with `word_o` holding the captured bits, and it never occurs while `cs_n_i` is still low.
- R4: If `cs_n_i` rises after any bit count other than 16, the frame is dropped. No pulse is issued, and `word_o` keeps the last delivered word.
- R5: A word sent as two 8-bit bursts, with an idle pause between them and `cs_n_i` held low throughout, is delivered the same way as a continuous 16-bit frame.
- R6: With `dout_mode_i` = 0, `dout_o` changes only after falling `sclk_i` edges. After each falling edge it shows the bit captured 15 rising edges before the preceding rising edge, which is a 16-clock lag.
- R7: With `dout_mode_i` = 1, `dout_o` changes only after rising `sclk_i` edges. After each rising edge it shows the bit captured 15 rising edges earlier, which is a 15.5-clock lag.
- R8: While `shutdown_i` is 1, `dout_o` holds its level. Shifting still takes place and words are still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low frame select (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| din_i | input | 1 | Serial data in |
| dout_mode_i | input | 1 | Echo launch edge: 0 falling, 1 rising |
| shutdown_i | input | 1 | Freezes the echo output when 1 |
| dout_o | output | 1 | Serial echo output |
| word_o | output | 16 | Last delivered word |
| word_valid_o | output | 1 | One-cycle strobe for a new word |

## Verification
The bench samples the echo output late in every serial clock phase. This separates the two launch edges: a design that used the wrong edge, or was off by one bit position, shows a stale or early bit in the high phase. Short and long frames are sent to catch a design that strobes on the 16th clock or accepts a miscounted frame. Such a design would produce unexpected strobes or overwrite the held word. A frame split into two bytes with a pause in the middle checks that the bit count survives idle time with select held low. A frame sent during shutdown checks that the echo stays put while words are still delivered.

// File: rtl/sdsr_pkg.sv
package sdsr_pkg;

    localparam int WORD_W  = 16;
    localparam int CTL_W   = 3;
    localparam int DATA_W  = 12;
    localparam int CNT_W   = $clog2(WORD_W + 2);

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] data;
        logic              sub;
    } dac_word_t;

    typedef enum logic {
        LAUNCH_FALL = 1'b0,
        LAUNCH_RISE = 1'b1
    } launch_e;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_rise;
        logic cs_active;
    } edge_t;

    function automatic logic [CNT_W-1:0] cnt_sat_inc(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] lim;
        lim = CNT_W'(WORD_W + 1);
        return (c >= lim) ? lim : c + 1'b1;
    endfunction

endpackage

// File: rtl/sdsr_sync.sv
module sdsr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdsr_edge.sv
module sdsr_edge
    import sdsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  cs_n_s,
    output edge_t ev
);
    logic sclk_q;
    logic cs_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_n_q <= cs_n_s;
        end
    end

    always_comb begin
        ev.sclk_rise = sclk_s & ~sclk_q;
        ev.sclk_fall = ~sclk_s & sclk_q;
        ev.cs_rise   = cs_n_s & ~cs_n_q;
        ev.cs_active = ~cs_n_s;
    end
endmodule

// File: rtl/sdsr_frame.sv
module sdsr_frame
    import sdsr_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_t         ev,
    input  logic          din_s,
    output logic [W-1:0]  word,
    output logic          word_valid,
    output logic [CW-1:0] bit_cnt,
    output logic          msb_now,
    output logic          msb_next
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= '0;
            bit_cnt    <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (ev.sclk_rise && ev.cs_active) begin
                sr      <= {sr[W-2:0], din_s};
                bit_cnt <= cnt_sat_inc(bit_cnt);
            end
            if (ev.cs_rise) begin
                if (bit_cnt == CW'(W)) begin
                    word       <= sr;
                    word_valid <= 1'b1;
                end
                bit_cnt <= '0;
            end
        end
    end

    assign msb_now  = sr[W-1];
    assign msb_next = sr[W-2];
endmodule

// File: rtl/sdsr_dout.sv
module sdsr_dout
    import sdsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  edge_t   ev,
    input  launch_e mode,
    input  logic    freeze,
    input  logic    msb_now,
    input  logic    msb_next,
    output logic    dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
        end else if (!freeze && ev.cs_active) begin
            case (mode)
                LAUNCH_FALL: if (ev.sclk_fall) dout <= msb_now;
                LAUNCH_RISE: if (ev.sclk_rise) dout <= msb_next;
                default:     dout <= dout;
            endcase
        end
    end
endmodule

// File: rtl/sdsr_top.sv
module sdsr_top
    import sdsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              din_i,
    input  logic              dout_mode_i,
    input  logic              shutdown_i,
    output logic              dout_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o
);
    logic [2:0]       raw_in;
    logic [2:0]       syn;
    edge_t            ev;
    logic             sclk_rise;
    logic             sclk_fall;
    logic [CNT_W-1:0] bit_cnt;
    logic             msb_now;
    logic             msb_next;
    launch_e          mode;

    assign raw_in = {cs_n_i, sclk_i, din_i};

    sdsr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(syn)
    );

    sdsr_edge u_edge (
        .clk(clk), .rst(rst), .sclk_s(syn[1]), .cs_n_s(syn[2]), .ev(ev)
    );

    assign sclk_rise = ev.sclk_rise;
    assign sclk_fall = ev.sclk_fall;

    sdsr_frame #(.W(WORD_W), .CW(CNT_W)) u_frame (
        .clk(clk), .rst(rst), .ev(ev), .din_s(syn[0]),
        .word(word_o), .word_valid(word_valid_o), .bit_cnt(bit_cnt),
        .msb_now(msb_now), .msb_next(msb_next)
    );

    assign mode = launch_e'(dout_mode_i);

    sdsr_dout u_dout (
        .clk(clk), .rst(rst), .ev(ev), .mode(mode), .freeze(shutdown_i),
        .msb_now(msb_now), .msb_next(msb_next), .dout(dout_o)
    );
endmodule

// File: rtl/sdsr_chk.sv
module sdsr_chk #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          dout_mode,
    input logic          shutdown,
    input logic          dout,
    input logic          word_valid,
    input logic [CW-1:0] bit_cnt,
    input logic          sclk_rise,
    input logic          sclk_fall
);
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    p_len_exact_r4: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(bit_cnt) == CW'(W)));

    p_fall_launch_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dout) && !$past(dout_mode)) |-> $past(sclk_fall));

    p_rise_launch_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(dout) && $past(dout_mode)) |-> $past(sclk_rise));

    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> $stable(dout));
endmodule

bind sdsr_top sdsr_chk #(.W(sdsr_pkg::WORD_W), .CW(sdsr_pkg::CNT_W)) u_chk (
    .clk(clk), .rst(rst), .dout_mode(dout_mode_i), .shutdown(shutdown_i),
    .dout(dout_o), .word_valid(word_valid_o), .bit_cnt(bit_cnt),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
);

// File: tb/tb_sdsr_top.sv
module tb_sdsr_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        mode = 1'b0;
    logic        shdn = 1'b0;
    logic        dout;
    logic [15:0] word;
    logic        valid;

    int n_checks = 0;
    int n_err = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_good = '0;
    logic [31:0] hist = '0;
    logic        frozen = 1'b0;
    int          skip = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdsr_top dut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
        .dout_mode_i(mode), .shutdown_i(shdn), .dout_o(dout),
        .word_o(word), .word_valid_o(valid)
    );

    task automatic chk_bit(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic sample_low();
        if (shdn) chk_bit(dout, frozen, "R8");
        else if (skip > 0) skip--;
        else chk_bit(dout, hist[15], mode ? "R7" : "R6");
    endtask

    task automatic sample_high();
        if (shdn) chk_bit(dout, frozen, "R8");
        else if (skip > 0) skip--;
        else if (mode) chk_bit(dout, hist[15], "R7");
        else chk_bit(dout, hist[16], "R6");
    endtask

    task automatic clock_bit(input logic b);
        @(negedge clk);
        din  = b;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sample_low();
        sclk = 1'b1;
        hist = {hist[30:0], b};
        repeat (HALF) @(negedge clk);
        sample_high();
    endtask

    // driver: pushes the expected word when the frame is well formed
    task automatic send_frame(input logic [15:0] w, input int nbits, input bit split);
        if (nbits == 16) begin
            exp_q.push_back(w);
            last_good = w;
        end
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (split && i == 8) begin
                @(negedge clk);
                sclk = 1'b0;
                repeat (25) @(negedge clk);
            end
            clock_bit((i < 16) ? w[15-i] : 1'b0);
        end
        @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sample_low();
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        if (nbits != 16) begin
            n_checks++;
            if (word !== last_good) begin
                n_err++;
                $display("FAIL R4: word actual %h expected %h", word, last_good);
            end
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && valid) begin
            n_checks++;
            if (cs_n !== 1'b1) begin
                n_err++;
                $display("FAIL R3: strobe with select low actual %0b expected 1", cs_n);
            end
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R4: unexpected strobe actual %h expected none", word);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                n_checks++;
                if (word !== e) begin
                    n_err++;
                    $display("FAIL R2: word actual %h expected %h", word, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit(dout, 1'b0, "R1");
        chk_bit(valid, 1'b0, "R1");
        n_checks++;
        if (word !== 16'h0) begin
            n_err++;
            $display("FAIL R1: word actual %h expected 0000", word);
        end

        // R2 R3 R6: falling-edge echo, continuous frames (sub-bit 0)
        mode = 1'b0;
        send_frame(16'hA5F0, 16, 0);
        send_frame(16'h3FFE, 16, 0);
        send_frame(16'h4002, 16, 0);

        // R7: rising-edge echo
        mode = 1'b1;
        send_frame(16'hC3A6, 16, 0);
        send_frame(16'h0000, 16, 0);
        send_frame(16'h7FFE, 16, 0);

        // R4: short and long frames are dropped
        send_frame(16'hFFFE, 8, 0);
        mode = 1'b0;
        send_frame(16'h1234, 17, 0);
        send_frame(16'h5556, 15, 0);

        // R5: two bytes with a pause, both echo modes
        send_frame(16'h9ABC, 16, 1);
        mode = 1'b1;
        send_frame(16'h2468, 16, 1);

        // R8: echo frozen, word still delivered
        @(negedge clk);
        shdn = 1'b1;
        repeat (3) @(negedge clk);
        frozen = dout;
        send_frame(16'hF0F0, 16, 0);
        mode = 1'b0;
        send_frame(16'h0F0E, 16, 0);
        @(negedge clk);
        shdn = 1'b0;
        skip = 2;
        send_frame(16'hBEEE, 16, 0);
        mode = 1'b1;
        send_frame(16'h1112, 16, 0);

        repeat (20) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL R3: missing strobes actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule